// File: doc/BRIEF.md
# Byte-Wide Access to a 16-bit Capture/TOP Register

This block sits between an 8-bit CPU register bus and a 16-bit register that holds either a captured timer value or the counter's TOP limit. The bus reaches the word through two byte addresses. One shared temporary byte keeps both halves of every word transfer consistent. Software reads the low byte first: that access returns the live low byte and, in the same step, freezes the current high byte into the temporary byte. The following high-byte read returns the frozen copy. Software writes the high byte first: that access fills only the temporary byte. The low-byte write that follows commits all sixteen bits in one clock edge.

Software writes reach the word only while the 4-bit waveform-mode input selects a mode in which this register acts as the counter TOP. The set of such mode codes is a parameter. A hardware capture strobe loads a full 16-bit value directly and beats a CPU commit that lands in the same cycle. The word is exported for the counter logic. The bus read data is combinational on the address.

Top module: `split_word_reg`

## Requirements
- R1: After reset the word is 0x0000 and the temporary byte is 0x00, so a high-byte read returns 0x00.
- R2: A read of the low-byte address (busAddr = 0) returns bits 7:0 of the word in the same cycle.
- R3: A low-byte read (busRd = 1, busWr = 0, busAddr = 0) copies bits 15:8 of the word into the temporary byte at that clock edge.
- R4: A read of the high-byte address (busAddr = 1) returns the temporary byte, not the live bits 15:8 of the word.
- R5: A write to the high-byte address loads only the temporary byte, whatever the mode. The word is unchanged at the next edge.
- R6: A write to the low-byte address while waveMode holds a TOP mode sets the word to {temporary byte, written byte} at that edge.
- R7: With the default parameters the TOP modes are codes 8, 10, 12 and 14. A low-byte write under any other code leaves the word unchanged.
- R8: The mode is judged by its value in the cycle of the low-byte write, not its value at the earlier high-byte write.
- R9: When capLoad is 1, the word takes capValue at that edge, even if a CPU low-byte write falls in the same cycle.
- R10: There is only one temporary byte. A high-byte write followed by a low-byte read leaves the snapshot of the word's high byte in it, and the written byte is lost.
- R11: When busRd and busWr are both 1, the access is treated as a write alone and no snapshot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busRd | input | 1 | CPU read strobe |
| busWr | input | 1 | CPU write strobe |
| busAddr | input | 1 | 0 selects the low byte, 1 selects the high byte |
| busWdata | input | 8 | CPU write byte |
| busRdata | output | 8 | CPU read byte |
| waveMode | input | 4 | Current waveform-mode code |
| capLoad | input | 1 | Hardware capture strobe |
| capValue | input | 16 | Captured counter value |
| regValue | output | 16 | Current word |

## Verification
Two functions can fall in the same clock cycle: a hardware capture and a CPU low-byte commit in a TOP mode. The bench provokes this by raising capLoad together with a low-byte write. It judges the result by requiring the word to equal the captured value, with no trace of the temporary or written byte. A second overlap, a read and a write strobe raised together, is judged by a later high-byte read showing that the temporary byte still holds the written byte and not a snapshot.

// File: rtl/split_word_pkg.sv
package split_word_pkg;
  // strobes from control to datapath, one per clock
  typedef struct packed {
    logic loadTemp;   // high-byte write fills temp
    logic snapTemp;   // low-byte read freezes high half
    logic commitWord; // low-byte write accepted
    logic capStore;   // hardware capture
  } regStrobe_t;
endpackage

// File: rtl/split_word_ctrl.sv
module split_word_ctrl
  import split_word_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int NUM_TOP = 4,
  parameter logic [NUM_TOP*MODE_W-1:0] TOP_MODE_LIST = {4'd14, 4'd12, 4'd10, 4'd8}
) (
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [MODE_W-1:0] waveMode,
  input  logic              capLoad,
  output logic              topHit,
  output regStrobe_t        strobe
);
  logic [NUM_TOP-1:0] hitVec;

  for (genvar i = 0; i < NUM_TOP; i++) begin : g_modeCmp
    assign hitVec[i] = (waveMode == TOP_MODE_LIST[i*MODE_W +: MODE_W]);
  end

  assign topHit = |hitVec;

  always_comb begin
    strobe.loadTemp   = busWr & busAddr;
    strobe.snapTemp   = busRd & ~busWr & ~busAddr;
    strobe.commitWord = busWr & ~busAddr & topHit & ~capLoad;
    strobe.capStore   = capLoad;
  end
endmodule

// File: rtl/split_word_dp.sv
module split_word_dp
  import split_word_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  logic                busAddr,
  input  logic [BYTE_W-1:0]   busWdata,
  input  logic [2*BYTE_W-1:0] capValue,
  output logic [BYTE_W-1:0]   busRdata,
  output logic [BYTE_W-1:0]   tempQ,
  output logic [2*BYTE_W-1:0] wordQ
);
  localparam int WORD_W = 2 * BYTE_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.capStore) begin
      wordQ <= capValue;
    end else if (strobe.commitWord) begin
      wordQ <= {tempQ, busWdata};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tempQ <= '0;
    end else if (strobe.loadTemp) begin
      tempQ <= busWdata;
    end else if (strobe.snapTemp) begin
      tempQ <= wordQ[WORD_W-1:BYTE_W];
    end
  end

  assign busRdata = busAddr ? tempQ : wordQ[BYTE_W-1:0];
endmodule

// File: rtl/split_word_reg.sv
module split_word_reg
  import split_word_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int MODE_W = 4,
  parameter int NUM_TOP = 4,
  parameter logic [NUM_TOP*MODE_W-1:0] TOP_MODE_LIST = {4'd14, 4'd12, 4'd10, 4'd8}
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busRd,
  input  logic                busWr,
  input  logic                busAddr,
  input  logic [BYTE_W-1:0]   busWdata,
  output logic [BYTE_W-1:0]   busRdata,
  input  logic [MODE_W-1:0]   waveMode,
  input  logic                capLoad,
  input  logic [2*BYTE_W-1:0] capValue,
  output logic [2*BYTE_W-1:0] regValue
);
  regStrobe_t        strobe;
  logic              topHit;
  logic [BYTE_W-1:0] tempQ;

  split_word_ctrl #(
    .MODE_W(MODE_W), .NUM_TOP(NUM_TOP), .TOP_MODE_LIST(TOP_MODE_LIST)
  ) u_ctrl (
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .waveMode(waveMode),
    .capLoad(capLoad), .topHit(topHit), .strobe(strobe)
  );

  split_word_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .capValue(capValue), .busRdata(busRdata),
    .tempQ(tempQ), .wordQ(regValue)
  );
endmodule

// File: rtl/split_word_reg_chk.sv
module split_word_reg_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busRd,
  input logic                busWr,
  input logic                busAddr,
  input logic [BYTE_W-1:0]   busWdata,
  input logic [BYTE_W-1:0]   busRdata,
  input logic                capLoad,
  input logic [2*BYTE_W-1:0] capValue,
  input logic [2*BYTE_W-1:0] regValue,
  input logic                topHit
);
  // R2
  low_read_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busAddr) |-> busRdata == regValue[BYTE_W-1:0]);

  // R3
  snap_then_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busAddr && $past(busRd && !busWr && !busAddr && rstN))
      |-> busRdata == $past(regValue[2*BYTE_W-1:BYTE_W]));

  // R5
  high_write_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr && !capLoad) |=> $stable(regValue));

  // R6
  commit_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && topHit && !capLoad)
      |=> regValue[BYTE_W-1:0] == $past(busWdata));

  // R7
  gated_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busAddr && !topHit && !capLoad) |=> $stable(regValue));

  // R9
  capture_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    capLoad |=> regValue == $past(capValue));
endmodule

bind split_word_reg split_word_reg_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .capLoad(capLoad),
  .capValue(capValue), .regValue(regValue), .topHit(topHit)
);

// File: tb/split_word_reg_test.sv
`timescale 1ns/1ps
module split_word_reg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [3:0]  waveMode = '0;
  logic        capLoad = 1'b0;
  logic [15:0] capValue = '0;
  logic [15:0] regValue;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] expWord = '0;
  logic [7:0]  expTemp = '0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  split_word_reg uut (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .waveMode(waveMode),
    .capLoad(capLoad), .capValue(capValue), .regValue(regValue)
  );

  function automatic bit isTop(input logic [3:0] m);
    return (m == 4'd8) || (m == 4'd10) || (m == 4'd12) || (m == 4'd14);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, settle
  task automatic access(input logic rd, input logic wr, input logic addr,
                        input logic [7:0] d, input logic cap, input logic [15:0] cv,
                        output logic [7:0] rdata);
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = addr; busWdata = d;
    capLoad = cap; capValue = cv;
    #1 rdata = busRdata;
    @(posedge clk);
    #1;
    busRd = 1'b0; busWr = 1'b0; capLoad = 1'b0;
  endtask

  task automatic wrHigh(input logic [7:0] d);
    logic [7:0] r;
    access(1'b0, 1'b1, 1'b1, d, 1'b0, 16'h0, r);
    expTemp = d;
    check("R5", regValue, expWord);
  endtask

  task automatic wrLow(input logic [7:0] d, input string tag);
    logic [7:0] r;
    access(1'b0, 1'b1, 1'b0, d, 1'b0, 16'h0, r);
    if (isTop(waveMode)) expWord = {expTemp, d};
    check(tag, regValue, expWord);
  endtask

  task automatic rdLow(input string tag);
    logic [7:0] r;
    access(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, r);
    check(tag, {8'h00, r}, {8'h00, expWord[7:0]});
    expTemp = expWord[15:8];
  endtask

  task automatic rdHigh(input string tag);
    logic [7:0] r;
    access(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 16'h0, r);
    check(tag, {8'h00, r}, {8'h00, expTemp});
  endtask

  task automatic capture(input logic [15:0] v);
    logic [7:0] r;
    access(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, v, r);
    expWord = v;
    check("R9", regValue, expWord);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1;
    check("R1", regValue, 16'h0000);
    rdHigh("R1");
    @(negedge clk) rstN = 1'b1;

    // R6 R7: every mode code, word commits only in TOP modes
    for (int m = 0; m < 16; m++) begin
      waveMode = 4'(m);
      wrHigh(8'(m * 17) ^ 8'hA5);
      wrLow(8'(m * 3 + 1), isTop(4'(m)) ? "R6" : "R7");
      rdLow("R2");
      rdHigh("R4");
    end

    // R6: value sweep of the low byte in a TOP mode
    waveMode = 4'd14;
    for (int v = 0; v < 256; v++) begin
      wrHigh(~8'(v));
      wrLow(8'(v), "R6");
      rdLow("R2");
      rdHigh("R3");
    end

    // R8: mode judged at the low-byte write
    waveMode = 4'd8;  wrHigh(8'h3C);
    waveMode = 4'd0;  wrLow(8'hC3, "R8");
    waveMode = 4'd9;  wrHigh(8'h5A);
    waveMode = 4'd12; wrLow(8'h11, "R8");
    check("R8", regValue, 16'h5A11);

    // R4: snapshot survives a later capture of a new high byte
    capture(16'hBEEF);
    rdLow("R3");
    capture(16'h1234);
    rdHigh("R4");

    // R9: capture beats a coincident low-byte commit
    waveMode = 4'd10;
    wrHigh(8'h77);
    access(1'b0, 1'b1, 1'b0, 8'h66, 1'b1, 16'hCAFE, r);
    expWord = 16'hCAFE;
    check("R9", regValue, expWord);
    rdLow("R9");

    // R10: high write then low read overwrites the single temp byte
    wrHigh(8'h99);
    rdLow("R10");
    rdHigh("R10");
    wrLow(8'h01, "R10");
    check("R10", regValue, 16'hCA01);

    // R11: read+write together acts as a write, no snapshot
    capture(16'hF00D);
    access(1'b1, 1'b1, 1'b1, 8'h42, 1'b0, 16'h0, r);
    expTemp = 8'h42;
    rdHigh("R11");
    access(1'b1, 1'b1, 1'b0, 8'h24, 1'b0, 16'h0, r);
    expWord = {expTemp, 8'h24};
    check("R11", regValue, expWord);
    rdHigh("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule